// File: doc/BRIEF.md
# Multiplexed External Bus Access Sequencer

The sequencer sits between a CPU core that can issue a program fetch, a data read and a data write in the same cycle, and a single external 16-bit address bus and 16-bit data bus. The three requests are latched together and played out one at a time. The data write goes first, then the data read, then the program fetch. Each external access carries exactly one of three active-low space selects, for the program, data or I/O space. Each space holds 64K words of 16 bits.

Data-space addresses below 0x8000 never reach the external bus. They go to an internal port, and the window 0x7000–0x7FFF is flagged as on-chip peripheral registers. Only data addresses 0x8000–0xFFFF, all I/O addresses and all program addresses become external cycles. Wait states and write turnaround belong to a separate timing unit: the sequencer pulses a start strobe at the beginning of each external access and holds the access until that unit returns done. The core stays stalled until every request of the cycle has completed. All completion flags then pulse together, with the read and fetch data held on their outputs.

Top module: `ext_bus_seq`

## Requirements
- R1: Requests latched in one cycle are served strictly as write, then read, then fetch; absent kinds are left out of the order.
- R2: An absent request costs no cycle. Each access begins in the cycle right after the previous one ends, and the first begins in the cycle right after acceptance.
- R3: During an external access exactly one select is low: `prog_sel_no` for a fetch, `io_sel_no` for a read or write with its I/O flag (`rd_io_i`/`wr_io_i`) at 1, and `data_sel_no` for a read or write with that flag at 0.
- R4: A data-space access to 0x7000–0x7FFF is a one-cycle internal access with `int_req_o`=1 and `int_periph_o`=1. No select goes low and `tmg_start_o` stays 0.
- R5: A data-space address of 0x8000–0xFFFF is external. A data address below 0x7000 is a one-cycle internal access with `int_periph_o`=0.
- R6: I/O-space accesses are external at every address, including 0x7000–0x7FFF. They use the same address, start/done and select sequence as memory accesses.
- R7: `stall_o` is 1 from the cycle after acceptance up to and including the cycle in which the done flags pulse. That pulse comes one cycle after the last access ends, lasts one cycle, and raises exactly the flags of the requested kinds. `stall_o` is 0 in the following cycle.
- R8: `rd_data_o` and `fetch_data_o` hold the word sampled from `ext_rdata_i` in the cycle `tmg_done_i` is high, or from `int_rdata_i` in the internal access cycle.
- R9: All selects are high whenever no external access is in progress. `tmg_start_o` is a one-cycle pulse in the first cycle of each external access.
- R10: During an external write `ext_we_o`=1 and `ext_wdata_o` carries the write word. During external reads and fetches `ext_we_o`=0.
- R11: Request inputs are ignored while `stall_o` is 1. They start no access and change no result.
- R12: After reset `stall_o`, all done flags and `tmg_start_o` are 0, and all selects are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Program fetch request |
| fetch_addr_i | input | 16 | Program fetch address |
| rd_req_i | input | 1 | Data read request |
| rd_io_i | input | 1 | Read targets I/O space (1) or data space (0) |
| rd_addr_i | input | 16 | Read address |
| wr_req_i | input | 1 | Data write request |
| wr_io_i | input | 1 | Write targets I/O space (1) or data space (0) |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 16 | Write word |
| stall_o | output | 1 | Core must wait |
| fetch_done_o | output | 1 | Fetch completion pulse |
| fetch_data_o | output | 16 | Fetched word |
| rd_done_o | output | 1 | Read completion pulse |
| rd_data_o | output | 16 | Read word |
| wr_done_o | output | 1 | Write completion pulse |
| ext_addr_o | output | 16 | External address bus |
| ext_wdata_o | output | 16 | External write data |
| ext_we_o | output | 1 | External cycle is a write |
| ext_rdata_i | input | 16 | External read data |
| prog_sel_no | output | 1 | Program space select, active low |
| data_sel_no | output | 1 | Data space select, active low |
| io_sel_no | output | 1 | I/O space select, active low |
| tmg_start_o | output | 1 | Starts the timing unit for one access |
| tmg_done_i | input | 1 | Timing unit reports the access finished |
| int_req_o | output | 1 | Internal (on-chip) access strobe |
| int_we_o | output | 1 | Internal access is a write |
| int_periph_o | output | 1 | Internal access hits the peripheral window |
| int_addr_o | output | 16 | Internal access address |
| int_wdata_o | output | 16 | Internal write word |
| int_rdata_i | input | 16 | Internal read data |

## Verification
The bench attacks the address boundaries at 0x6FFF, 0x7000, 0x7FFF and 0x8000 in data space, and the same addresses in I/O space. A decoder off by one, or one that ignores the space, would put a peripheral access on the external bus or drop an external one. It mixes internal and external steps with timing-unit latencies of one to four cycles, and checks the cycle each step starts. A sequencer that idled on an absent request, or began the next access early, would show a shifted start. It also holds new requests high throughout a stall. A design that latched them would run extra accesses, which the scoreboard finds as items it never expected.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {SP_PROG, SP_DATA, SP_IO} space_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;
  // request kind index; higher index wins the bus first
  localparam int K_FETCH = 0;
  localparam int K_READ  = 1;
  localparam int K_WRITE = 2;
  localparam int NKIND   = 3;
endpackage

// File: rtl/ebs_arbiter.sv
module ebs_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebs_space_dec.sv
module ebs_space_dec
  import ebs_pkg::*;
#(
  parameter int          AW        = 16,
  parameter logic [AW-1:0] PERIPH_LO = 16'h7000,
  parameter logic [AW-1:0] PERIPH_HI = 16'h7FFF,
  parameter logic [AW-1:0] EXT_LO    = 16'h8000
) (
  input  space_e        space_i,
  input  logic [AW-1:0] addr_i,
  output logic          is_ext_o,
  output logic          is_periph_o
);
  logic in_data;
  assign in_data     = (space_i == SP_DATA);
  assign is_ext_o    = !in_data || (addr_i >= EXT_LO);
  assign is_periph_o = in_data && (addr_i >= PERIPH_LO) && (addr_i <= PERIPH_HI);
endmodule

// File: rtl/ebs_ctrl.sv
module ebs_ctrl
  import ebs_pkg::*;
#(
  parameter int N = NKIND
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] grant_i,
  input  logic         cur_ext_i,
  input  logic         tmg_done_i,
  output logic [N-1:0] pend_o,
  output logic         idle_o,
  output logic         run_o,
  output logic         started_o,
  output logic         step_done_o,
  output logic         stall_o,
  output logic [N-1:0] done_o
);
  state_e       state_q;
  logic [N-1:0] pend_q, mask_q, rest;
  logic         started_q;

  assign idle_o      = (state_q == ST_IDLE);
  assign run_o       = (state_q == ST_RUN);
  assign started_o   = started_q;
  assign pend_o      = pend_q;
  assign stall_o     = !idle_o;
  assign step_done_o = run_o && (!cur_ext_i || (started_q && tmg_done_i));
  assign rest        = pend_q & ~grant_i;
  assign done_o      = (state_q == ST_FIN) ? mask_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      mask_q    <= '0;
      started_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (|req_i) begin
          pend_q    <= req_i;
          mask_q    <= req_i;
          started_q <= 1'b0;
          state_q   <= ST_RUN;
        end
        ST_RUN: begin
          if (step_done_o) begin
            pend_q    <= rest;
            started_q <= 1'b0;
            if (rest == '0) state_q <= ST_FIN;
          end else if (cur_ext_i && !started_q) begin
            started_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] PERIPH_LO = 16'h7000,
  parameter logic [AW-1:0] PERIPH_HI = 16'h7FFF,
  parameter logic [AW-1:0] EXT_LO    = 16'h8000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          rd_req_i,
  input  logic          rd_io_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_req_i,
  input  logic          wr_io_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          stall_o,
  output logic          fetch_done_o,
  output logic [DW-1:0] fetch_data_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_done_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_wdata_o,
  output logic          ext_we_o,
  input  logic [DW-1:0] ext_rdata_i,
  output logic          prog_sel_no,
  output logic          data_sel_no,
  output logic          io_sel_no,
  output logic          tmg_start_o,
  input  logic          tmg_done_i,
  output logic          int_req_o,
  output logic          int_we_o,
  output logic          int_periph_o,
  output logic [AW-1:0] int_addr_o,
  output logic [DW-1:0] int_wdata_o,
  input  logic [DW-1:0] int_rdata_i
);
  logic [NKIND-1:0] req_vec, pend, grant, done_vec;
  logic             idle, run, started, step_done;
  logic             cur_ext, cur_periph, cur_io, ext_act;
  space_e           cur_sp;
  logic [AW-1:0]    cur_addr;
  logic [DW-1:0]    step_rdata;

  // latched request fields
  logic [AW-1:0] fa_q, ra_q, wa_q;
  logic [DW-1:0] wd_q, rd_q, fd_q;
  logic          rio_q, wio_q;

  assign req_vec[K_FETCH] = fetch_req_i;
  assign req_vec[K_READ]  = rd_req_i;
  assign req_vec[K_WRITE] = wr_req_i;

  ebs_ctrl #(.N(NKIND)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_vec),
    .grant_i    (grant),
    .cur_ext_i  (cur_ext),
    .tmg_done_i (tmg_done_i),
    .pend_o     (pend),
    .idle_o     (idle),
    .run_o      (run),
    .started_o  (started),
    .step_done_o(step_done),
    .stall_o    (stall_o),
    .done_o     (done_vec)
  );

  ebs_arbiter #(.N(NKIND)) u_arb (
    .pend_i (pend),
    .grant_o(grant)
  );

  always_comb begin
    if (grant[K_WRITE]) begin
      cur_addr = wa_q;
      cur_io   = wio_q;
    end else if (grant[K_READ]) begin
      cur_addr = ra_q;
      cur_io   = rio_q;
    end else begin
      cur_addr = fa_q;
      cur_io   = 1'b0;
    end
    if (grant[K_FETCH])  cur_sp = SP_PROG;
    else if (cur_io)     cur_sp = SP_IO;
    else                 cur_sp = SP_DATA;
  end

  ebs_space_dec #(
    .AW(AW), .PERIPH_LO(PERIPH_LO), .PERIPH_HI(PERIPH_HI), .EXT_LO(EXT_LO)
  ) u_dec (
    .space_i    (cur_sp),
    .addr_i     (cur_addr),
    .is_ext_o   (cur_ext),
    .is_periph_o(cur_periph)
  );

  assign ext_act     = run && cur_ext;
  assign tmg_start_o = ext_act && !started;
  assign prog_sel_no = !(ext_act && cur_sp == SP_PROG);
  assign data_sel_no = !(ext_act && cur_sp == SP_DATA);
  assign io_sel_no   = !(ext_act && cur_sp == SP_IO);
  assign ext_addr_o  = ext_act ? cur_addr : '0;
  assign ext_we_o    = ext_act && grant[K_WRITE];
  assign ext_wdata_o = ext_we_o ? wd_q : '0;

  assign int_req_o    = run && !cur_ext;
  assign int_we_o     = int_req_o && grant[K_WRITE];
  assign int_periph_o = int_req_o && cur_periph;
  assign int_addr_o   = int_req_o ? cur_addr : '0;
  assign int_wdata_o  = int_we_o ? wd_q : '0;

  assign step_rdata = cur_ext ? ext_rdata_i : int_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa_q  <= '0;
      ra_q  <= '0;
      wa_q  <= '0;
      wd_q  <= '0;
      rio_q <= 1'b0;
      wio_q <= 1'b0;
      rd_q  <= '0;
      fd_q  <= '0;
    end else begin
      if (idle && |req_vec) begin
        fa_q  <= fetch_addr_i;
        ra_q  <= rd_addr_i;
        wa_q  <= wr_addr_i;
        wd_q  <= wr_data_i;
        rio_q <= rd_io_i;
        wio_q <= wr_io_i;
      end
      if (step_done && grant[K_READ])  rd_q <= step_rdata;
      if (step_done && grant[K_FETCH]) fd_q <= step_rdata;
    end
  end

  assign rd_data_o    = rd_q;
  assign fetch_data_o = fd_q;
  assign fetch_done_o = done_vec[K_FETCH];
  assign rd_done_o    = done_vec[K_READ];
  assign wr_done_o    = done_vec[K_WRITE];
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stall_o,
  input logic prog_sel_no,
  input logic data_sel_no,
  input logic io_sel_no,
  input logic tmg_start_o,
  input logic int_req_o,
  input logic int_periph_o,
  input logic ext_we_o,
  input logic fetch_done_o,
  input logic rd_done_o,
  input logic wr_done_o
);
  logic [2:0] sels_n;
  logic       any_done;
  assign sels_n   = {io_sel_no, data_sel_no, prog_sel_no};
  assign any_done = fetch_done_o || rd_done_o || wr_done_o;

  // R3
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sels_n != 3'b111) |-> ($countones(~sels_n) == 1));

  // R9
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> (sels_n == 3'b111));

  // R9
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmg_start_o |=> !tmg_start_o);

  // R4
  periph_internal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_req_o && int_periph_o) |-> ((sels_n == 3'b111) && !tmg_start_o));

  // R7
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_done |-> stall_o ##1 !stall_o);

  // R10
  no_prog_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> prog_sel_no);
endmodule

bind ext_bus_seq ebs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_o     (stall_o),
  .prog_sel_no (prog_sel_no),
  .data_sel_no (data_sel_no),
  .io_sel_no   (io_sel_no),
  .tmg_start_o (tmg_start_o),
  .int_req_o   (int_req_o),
  .int_periph_o(int_periph_o),
  .ext_we_o    (ext_we_o),
  .fetch_done_o(fetch_done_o),
  .rd_done_o   (rd_done_o),
  .wr_done_o   (wr_done_o)
);

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        fetch_req, rd_req, rd_io, wr_req, wr_io;
  logic [15:0] fetch_addr, rd_addr, wr_addr, wr_data;
  logic        stall, fetch_done, rd_done, wr_done;
  logic [15:0] fetch_data, rd_data, ext_addr, ext_wdata, ext_rdata;
  logic        ext_we, prog_sel_n, data_sel_n, io_sel_n, tmg_start, tmg_done;
  logic        int_req, int_we, int_periph;
  logic [15:0] int_addr, int_wdata, int_rdata;

  ext_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr),
    .rd_req_i(rd_req), .rd_io_i(rd_io), .rd_addr_i(rd_addr),
    .wr_req_i(wr_req), .wr_io_i(wr_io), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .stall_o(stall), .fetch_done_o(fetch_done), .fetch_data_o(fetch_data),
    .rd_done_o(rd_done), .rd_data_o(rd_data), .wr_done_o(wr_done),
    .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata), .ext_we_o(ext_we),
    .ext_rdata_i(ext_rdata), .prog_sel_no(prog_sel_n), .data_sel_no(data_sel_n),
    .io_sel_no(io_sel_n), .tmg_start_o(tmg_start), .tmg_done_i(tmg_done),
    .int_req_o(int_req), .int_we_o(int_we), .int_periph_o(int_periph),
    .int_addr_o(int_addr), .int_wdata_o(int_wdata), .int_rdata_i(int_rdata)
  );

  // external and internal memory models: word depends on address and space
  assign ext_rdata = ext_addr ^ (!prog_sel_n ? 16'h1111 :
                                 !data_sel_n ? 16'h2222 :
                                 !io_sel_n   ? 16'h4444 : 16'h0000);
  assign int_rdata = int_addr ^ 16'h5A5A;

  int checks = 0, fails = 0, cyc = 0, last_step = 0, tm_lat = 1, tm_cnt = 0;
  bit finished = 0;
  logic [35:0] ext_q[$];   // {sels_n, addr, we, wdata}
  logic [33:0] int_q[$];   // {addr, we, wdata, periph}

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // timing-unit model and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic busy;
      logic [2:0] s;
      if (tmg_start) begin
        tm_cnt = tm_lat; tmg_done = 1'b0;
      end else if (tm_cnt > 0) begin
        tm_cnt--; tmg_done = (tm_cnt == 0);
      end else tmg_done = 1'b0;
      busy = tmg_start || tmg_done || (tm_cnt > 0);
      s = {io_sel_n, data_sel_n, prog_sel_n};
      if (busy) chk("R3 one select", 36'($countones(~s)), 36'd1);
      else      chk("R9 selects idle", 36'(s), 36'h7);
      if (tmg_start) begin
        chk("R2 start cycle", 36'(cyc), 36'(last_step + 1));
        if (ext_q.size() == 0) chk("R11 unexpected ext access", {s, ext_addr, ext_we, ext_wdata}, 36'h0);
        else chk("R1/R6/R10 ext access", {s, ext_addr, ext_we, ext_wdata}, ext_q.pop_front());
      end
      if (tmg_done) last_step = cyc;
      if (int_req) begin
        chk("R2 internal step cycle", 36'(cyc), 36'(last_step + 1));
        chk("R4 internal no select", {32'd0, s, tmg_start}, {32'd0, 3'b111, 1'b0});
        if (int_q.size() == 0) chk("R11 unexpected int access", 36'({int_addr, int_we, int_wdata, int_periph}), 36'h0);
        else chk("R4/R5 int access", 36'({int_addr, int_we, int_wdata, int_periph}), 36'(int_q.pop_front()));
        last_step = cyc;
      end
    end else tmg_done = 1'b0;
  end

  function automatic void push_exp(input logic [1:0] kind, input logic io, input logic [15:0] a,
                                   input logic [15:0] wd);
    logic we;
    we = (kind == 2);
    if (kind == 0) ext_q.push_back({3'b110, a, 1'b0, 16'h0});
    else if (io)   ext_q.push_back({3'b011, a, we, we ? wd : 16'h0});
    else if (a >= 16'h8000) ext_q.push_back({3'b101, a, we, we ? wd : 16'h0});
    else int_q.push_back({a, we, we ? wd : 16'h0, (a >= 16'h7000)});
  endfunction

  task automatic set_idle_inputs();
    fetch_req = 0; rd_req = 0; wr_req = 0; rd_io = 0; wr_io = 0;
    fetch_addr = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic run_txn(input string tag, input bit fr, input logic [15:0] fa,
                         input bit rr, input bit rio, input logic [15:0] ra,
                         input bit wr, input bit wio, input logic [15:0] wa, input logic [15:0] wd,
                         input int lat, input bit noise);
    logic [15:0] exp_rd, exp_fd;
    int n;
    if (wr) push_exp(2, wio, wa, wd);
    if (rr) push_exp(1, rio, ra, 16'h0);
    if (fr) push_exp(0, 1'b0, fa, 16'h0);
    exp_rd = (!rio && ra < 16'h8000) ? (ra ^ 16'h5A5A) : (ra ^ (rio ? 16'h4444 : 16'h2222));
    exp_fd = fa ^ 16'h1111;
    @(negedge clk);
    tm_lat = lat;
    fetch_req = fr; fetch_addr = fa; rd_req = rr; rd_io = rio; rd_addr = ra;
    wr_req = wr; wr_io = wio; wr_addr = wa; wr_data = wd;
    last_step = cyc;
    @(negedge clk);
    if (noise) begin
      fetch_req = 1; rd_req = 1; wr_req = 1; rd_io = 0; wr_io = 0;
      fetch_addr = 16'h0BAD; rd_addr = 16'h8BAD; wr_addr = 16'h9BAD; wr_data = 16'hDEAD;
    end else set_idle_inputs();
    chk({"R7 stall after accept ", tag}, 36'(stall), 36'd1);
    n = 0;
    while (!(fetch_done || rd_done || wr_done) && n < 300) begin
      @(negedge clk); n++;
    end
    set_idle_inputs();
    chk({"R7 done cycle ", tag}, 36'(cyc), 36'(last_step + 1));
    chk({"R7 done flags ", tag}, {32'd0, stall, wr_done, rd_done, fetch_done}, {32'd0, 1'b1, wr, rr, fr});
    if (rr) chk({"R8 read data ", tag}, 36'(rd_data), 36'(exp_rd));
    if (fr) chk({"R8 fetch data ", tag}, 36'(fetch_data), 36'(exp_fd));
    chk({"R1/R11 queues drained ", tag}, 36'(ext_q.size() + int_q.size()), 36'd0);
    ext_q.delete(); int_q.delete();
    @(negedge clk);
    chk({"R7 release ", tag}, {33'd0, stall, tmg_start, int_req}, 36'd0);
  endtask

  initial begin
    set_idle_inputs();
    tmg_done = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset", {30'd0, stall, fetch_done, rd_done, wr_done, tmg_start, int_req},
        36'd0);
    chk("R12 selects", 36'({io_sel_n, data_sel_n, prog_sel_n}), 36'h7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 all three external, data space
    run_txn("R1 data", 1, 16'h1234, 1, 0, 16'hA000, 1, 0, 16'h9000, 16'hC0DE, 1, 0);
    // R6 all three with I/O read/write, longer latency
    run_txn("R6 io", 1, 16'hFFFF, 1, 1, 16'h0003, 1, 1, 16'h0010, 16'h5555, 3, 0);
    // R2 only fetch
    run_txn("R2 fetch only", 1, 16'h0040, 0, 0, 16'h0, 0, 0, 16'h0, 16'h0, 2, 0);
    // R4 peripheral read + fetch
    run_txn("R4 periph rd", 1, 16'h2000, 1, 0, 16'h7010, 0, 0, 16'h0, 16'h0, 1, 0);
    // R4/R5 peripheral write at top edge + external read at window base
    run_txn("R5 edges", 0, 16'h0, 1, 0, 16'h8000, 1, 0, 16'h7FFF, 16'hBEEF, 2, 0);
    // R5 below peripheral window, write at window base
    run_txn("R5 low", 1, 16'h0100, 1, 0, 16'h6FFF, 1, 0, 16'h7000, 16'h1357, 1, 0);
    // R6 I/O in peripheral range stays external
    run_txn("R6 io periph range", 0, 16'h0, 1, 1, 16'h7FFF, 1, 1, 16'h7005, 16'h2468, 4, 0);
    // R11 requests held during stall
    run_txn("R11 noise", 1, 16'h3000, 1, 0, 16'hFFFF, 1, 0, 16'h8001, 16'hAAAA, 2, 1);
    // R10 write only external, R8 read only top
    run_txn("R10 wr only", 0, 16'h0, 0, 0, 16'h0, 1, 0, 16'hFFFE, 16'h0F0F, 1, 0);
    run_txn("R8 rd only", 0, 16'h0, 1, 0, 16'hFFFF, 0, 0, 16'h0, 16'h0, 1, 0);
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule